// File: doc/BRIEF.md
# One-of-N Interrupt Target Selector

This block picks a single destination core for a shared peripheral interrupt that has been programmed for one-of-N delivery. Each core reports several things to the block: an advisory activity flag, whether it is asleep, per-group disable bits, per-group processor enables, a class bit, and whether it already has work pending along with that work's best priority. The interrupt itself brings its group, priority, routing mode, fixed target and a two-bit class mask. Global group enables and a wake enable complete the inputs.

Selection filters the cores first. Any core that is asleep, has the group turned off, or falls outside the class mask is removed. The remaining cores then go through two passes that share one round-robin pointer. The first pass looks for an idle core with its activity flag high. The second pass looks for a core holding nothing more urgent than this interrupt. If neither pass finds a core, the interrupt is parked on any legal core and evaluated again after a fixed number of cycles. If no awake core survives the group-disable and class filters, the block can ask for exactly one sleeping core to be woken.

The interrupt is presented as a level. A result appears on the registered outputs one clock after the block sees that level, and it is held until the level drops.

Top module: `oon_target_sel`

## Requirements
- R1: With `irq_mode_i` = 0 the block outputs `tgt_o` = `irq_fixed_i` with `tgt_vld_o` = 1 and performs no selection. The round-robin pointer is left unchanged.
- R2: A core is never chosen if it is asleep, if its processor enable for the interrupt's group (bit `c*NGRP+g` of `core_grp_en_i`) is 0, or if global enable bit `g` of `glob_grp_en_i` is 0. When no core is legal, `tgt_vld_o` = 0 and `tgt_o` = 0.
- R3: A core whose disabled-group bit (bit `c*NGRP+g` of `core_grp_dis_i`) is 1 never receives a one-of-N interrupt of group `g`.
- R4: A core with class bit 0 is eligible only if bit 0 of `irq_cmask_i` is 1. A core with class bit 1 is eligible only if bit 1 of the mask is 1. The mask value 2'b11 (both classes, the reset value of the mask) admits every core.
- R5: The first pass grants, in round-robin order, an eligible core with `core_active_i` = 1 and `core_pend_any_i` = 0. This pass is preferred over the second pass even when the pointer reaches another core first.
- R6: If the first pass is empty, the second pass grants, in round-robin order, an eligible core with no pending interrupt or whose pending priority is not numerically lower than `irq_prio_i`. A lower value means a higher priority.
- R7: If both passes are empty but some core is legal, one legal core is granted round-robin. The result is held and evaluated again `REEVAL_CYC`+1 clocks later for as long as the interrupt stays pending. The same holds when no core is legal.
- R8: `core_active_i` is advisory only. A core with it low is still selected by the second pass or the fallback.
- R9: Round-robin search starts at a pointer that resets to core 0. After every one-of-N grant the pointer moves to the core after the granted one, wrapping from N-1 to 0. The pointer is shared by all passes.
- R10: When `irq_mode_i` = 1, `wake_en_i` = 1, and no awake core passes the group-disable and class filters, `wake_o` pulses for one clock. It carries a one-hot request for the first filter-passing asleep core in round-robin order. The pulse is given at most once per pending episode of the interrupt.
- R11: A result appears one clock after `irq_pend_i` is first seen high. In the held state it stays stable whatever the core inputs do. `tgt_vld_o` and `wake_o` are 0 one clock after `irq_pend_i` is seen low.
- R12: While `rst` is high, `tgt_o` = 0, `tgt_vld_o` = 0 and `wake_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_active_i | input | N | Per-core advisory activity flag |
| core_asleep_i | input | N | Per-core asleep status |
| core_grp_dis_i | input | N*NGRP | Per-core, per-group one-of-N disable, bit c*NGRP+g |
| core_grp_en_i | input | N*NGRP | Per-core, per-group processor enable, bit c*NGRP+g |
| core_class_i | input | N | Per-core class bit |
| core_pend_any_i | input | N | Core already has a pending interrupt |
| core_pend_prio_i | input | N*PRIO_W | Best pending priority per core, field c at c*PRIO_W |
| glob_grp_en_i | input | NGRP | Global per-group enable |
| wake_en_i | input | 1 | Allow waking one core when no awake core qualifies |
| irq_pend_i | input | 1 | Interrupt awaiting a target (level) |
| irq_grp_i | input | max(1,clog2(NGRP)) | Interrupt group |
| irq_prio_i | input | PRIO_W | Interrupt priority, lower value is more urgent |
| irq_mode_i | input | 1 | 0: fixed target, 1: one-of-N |
| irq_fixed_i | input | max(1,clog2(N)) | Fixed target core |
| irq_cmask_i | input | 2 | Admitted classes, bit k admits class k |
| tgt_o | output | max(1,clog2(N)) | Chosen core |
| tgt_vld_o | output | 1 | Chosen core is valid |
| wake_o | output | N | One-hot wake request pulse |

## Verification
The bench builds the block with four cores, two groups, 4-bit priorities and a re-evaluation interval of six cycles. Four cores are enough to walk the shared pointer through a complete wrap. They also let both passes run against the same pointer, and let a preferred active core sit behind a core that the pointer reaches first. Two groups exercise the per-core and global group bits independently of each other. The short interval keeps a full hold-and-re-evaluate round trip, and several repeated checks that no second wake pulse follows, within a few dozen cycles.

// File: rtl/oon_pkg.sv
package oon_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_WAIT = 2'd2
  } oon_st_e;

  function automatic int w_of(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/oon_elig_filter.sv
module oon_elig_filter #(
  parameter int N      = 4,
  parameter int NGRP   = 2,
  parameter int PRIO_W = 4
) (
  input  logic [N-1:0]                     core_active_i,
  input  logic [N-1:0]                     core_asleep_i,
  input  logic [N*NGRP-1:0]                core_grp_dis_i,
  input  logic [N*NGRP-1:0]                core_grp_en_i,
  input  logic [N-1:0]                     core_class_i,
  input  logic [N-1:0]                     core_pend_any_i,
  input  logic [N*PRIO_W-1:0]              core_pend_prio_i,
  input  logic [NGRP-1:0]                  glob_grp_en_i,
  input  logic [oon_pkg::w_of(NGRP)-1:0]   irq_grp_i,
  input  logic [PRIO_W-1:0]                irq_prio_i,
  input  logic [1:0]                       irq_cmask_i,
  output logic [N-1:0]                     legal_o,
  output logic [N-1:0]                     pass1_o,
  output logic [N-1:0]                     pass2_o,
  output logic [N-1:0]                     awake_ok_o,
  output logic [N-1:0]                     wake_cand_o
);
  localparam int GRP_W = oon_pkg::w_of(NGRP);

  for (genvar c = 0; c < N; c++) begin : g_core
    logic grp_dis, grp_en, glob_en, cls_ok, hi_pend, base_ok, legal;

    always_comb begin
      grp_dis = 1'b1;
      grp_en  = 1'b0;
      glob_en = 1'b0;
      for (int g = 0; g < NGRP; g++) begin
        if (irq_grp_i == GRP_W'(g)) begin
          grp_dis = core_grp_dis_i[c*NGRP+g];
          grp_en  = core_grp_en_i[c*NGRP+g];
          glob_en = glob_grp_en_i[g];
        end
      end
      cls_ok  = core_class_i[c] ? irq_cmask_i[1] : irq_cmask_i[0];
      hi_pend = core_pend_any_i[c] &&
                (core_pend_prio_i[c*PRIO_W +: PRIO_W] < irq_prio_i);
      base_ok = !grp_dis && cls_ok;
      legal   = base_ok && !core_asleep_i[c] && grp_en && glob_en;
    end

    assign legal_o[c]     = legal;
    assign pass1_o[c]     = legal && core_active_i[c] && !core_pend_any_i[c];
    assign pass2_o[c]     = legal && !hi_pend;
    assign awake_ok_o[c]  = base_ok && !core_asleep_i[c];
    assign wake_cand_o[c] = base_ok && core_asleep_i[c];
  end

endmodule

// File: rtl/oon_rr_pick.sv
module oon_rr_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0]                   req_i,
  input  logic [oon_pkg::w_of(N)-1:0]    ptr_i,
  output logic [N-1:0]                   gnt_oh_o,
  output logic                           any_o
);
  localparam int IDX_W = oon_pkg::w_of(N);

  logic [IDX_W:0] pos;

  always_comb begin
    gnt_oh_o = '0;
    any_o    = 1'b0;
    pos      = '0;
    for (int k = 0; k < N; k++) begin
      pos = {1'b0, ptr_i} + (IDX_W+1)'(k);
      if (pos >= (IDX_W+1)'(N)) pos = pos - (IDX_W+1)'(N);
      if (!any_o && req_i[pos[IDX_W-1:0]]) begin
        any_o = 1'b1;
        gnt_oh_o[pos[IDX_W-1:0]] = 1'b1;
      end
    end
  end

  // R9: a grant is one-hot and only ever lands on a requesting core
  always_comb begin
    a_r9_gnt_subset: assert ((gnt_oh_o & ~req_i) == '0);
    a_r9_gnt_onehot: assert ($onehot0(gnt_oh_o) && (any_o == (gnt_oh_o != '0)));
  end

endmodule

// File: rtl/oon_reeval_tmr.sv
module oon_reeval_tmr #(
  parameter int CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic run_i,
  output logic done_o
);
  localparam int CNT_W = oon_pkg::w_of(CYC);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (start_i) begin
      cnt_q <= CNT_W'(CYC-1);
    end else if (run_i && cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign done_o = run_i && (cnt_q == '0);

  // R7: a freshly loaded window cannot report done on the following clock
  a_r7_window_open: assert property (@(posedge clk) disable iff (rst)
    (start_i && CYC > 1) |=> !done_o);

endmodule

// File: rtl/oon_target_sel.sv
module oon_target_sel #(
  parameter int N          = 4,
  parameter int NGRP       = 2,
  parameter int PRIO_W     = 4,
  parameter int REEVAL_CYC = 16
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [N-1:0]                      core_active_i,
  input  logic [N-1:0]                      core_asleep_i,
  input  logic [N*NGRP-1:0]                 core_grp_dis_i,
  input  logic [N*NGRP-1:0]                 core_grp_en_i,
  input  logic [N-1:0]                      core_class_i,
  input  logic [N-1:0]                      core_pend_any_i,
  input  logic [N*PRIO_W-1:0]               core_pend_prio_i,
  input  logic [NGRP-1:0]                   glob_grp_en_i,
  input  logic                              wake_en_i,
  input  logic                              irq_pend_i,
  input  logic [oon_pkg::w_of(NGRP)-1:0]    irq_grp_i,
  input  logic [PRIO_W-1:0]                 irq_prio_i,
  input  logic                              irq_mode_i,
  input  logic [oon_pkg::w_of(N)-1:0]       irq_fixed_i,
  input  logic [1:0]                        irq_cmask_i,
  output logic [oon_pkg::w_of(N)-1:0]       tgt_o,
  output logic                              tgt_vld_o,
  output logic [N-1:0]                      wake_o
);
  import oon_pkg::*;

  localparam int IDX_W = w_of(N);

  function automatic logic [IDX_W-1:0] oh2idx(input logic [N-1:0] oh);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = 0; i < N; i++) begin
      if (oh[i]) r = r | IDX_W'(i);
    end
    return r;
  endfunction

  oon_st_e          st_q;
  logic [IDX_W-1:0] ptr_q;
  logic             woke_q;

  logic [N-1:0] legal_m, p1_m, p2_m, awake_m, wcand_m;
  logic [N-1:0] p1_oh, p2_oh, fb_oh, wk_oh, sel_oh;
  logic         p1_any, p2_any, fb_any, wk_any;
  logic [IDX_W-1:0] sel_idx, sel_next;
  logic         eval, go_wait, do_wake, tmr_done;

  oon_elig_filter #(.N(N), .NGRP(NGRP), .PRIO_W(PRIO_W)) u_filt (
    .core_active_i    (core_active_i),
    .core_asleep_i    (core_asleep_i),
    .core_grp_dis_i   (core_grp_dis_i),
    .core_grp_en_i    (core_grp_en_i),
    .core_class_i     (core_class_i),
    .core_pend_any_i  (core_pend_any_i),
    .core_pend_prio_i (core_pend_prio_i),
    .glob_grp_en_i    (glob_grp_en_i),
    .irq_grp_i        (irq_grp_i),
    .irq_prio_i       (irq_prio_i),
    .irq_cmask_i      (irq_cmask_i),
    .legal_o          (legal_m),
    .pass1_o          (p1_m),
    .pass2_o          (p2_m),
    .awake_ok_o       (awake_m),
    .wake_cand_o      (wcand_m)
  );

  oon_rr_pick #(.N(N)) u_pick_p1 (.req_i(p1_m),    .ptr_i(ptr_q), .gnt_oh_o(p1_oh), .any_o(p1_any));
  oon_rr_pick #(.N(N)) u_pick_p2 (.req_i(p2_m),    .ptr_i(ptr_q), .gnt_oh_o(p2_oh), .any_o(p2_any));
  oon_rr_pick #(.N(N)) u_pick_fb (.req_i(legal_m), .ptr_i(ptr_q), .gnt_oh_o(fb_oh), .any_o(fb_any));
  oon_rr_pick #(.N(N)) u_pick_wk (.req_i(wcand_m), .ptr_i(ptr_q), .gnt_oh_o(wk_oh), .any_o(wk_any));

  always_comb begin
    sel_oh   = p1_any ? p1_oh : (p2_any ? p2_oh : fb_oh);
    sel_idx  = oh2idx(sel_oh);
    sel_next = (sel_idx == IDX_W'(N-1)) ? '0 : sel_idx + IDX_W'(1);
    eval     = (st_q == ST_IDLE) && irq_pend_i;
    go_wait  = eval && irq_mode_i && !p1_any && !p2_any;
    do_wake  = eval && irq_mode_i && wake_en_i && !(|awake_m) && wk_any && !woke_q;
  end

  oon_reeval_tmr #(.CYC(REEVAL_CYC)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .start_i (go_wait),
    .run_i   (st_q == ST_WAIT),
    .done_o  (tmr_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      ptr_q     <= '0;
      woke_q    <= 1'b0;
      tgt_o     <= '0;
      tgt_vld_o <= 1'b0;
      wake_o    <= '0;
    end else begin
      wake_o <= '0;
      if (!irq_pend_i) begin
        st_q      <= ST_IDLE;
        woke_q    <= 1'b0;
        tgt_o     <= '0;
        tgt_vld_o <= 1'b0;
      end else begin
        case (st_q)
          ST_IDLE: begin
            if (!irq_mode_i) begin
              tgt_o     <= irq_fixed_i;
              tgt_vld_o <= 1'b1;
              st_q      <= ST_HOLD;
            end else if (p1_any || p2_any || fb_any) begin
              tgt_o     <= sel_idx;
              tgt_vld_o <= 1'b1;
              ptr_q     <= sel_next;
              st_q      <= go_wait ? ST_WAIT : ST_HOLD;
            end else begin
              tgt_o     <= '0;
              tgt_vld_o <= 1'b0;
              st_q      <= ST_WAIT;
            end
            if (do_wake) begin
              wake_o <= wk_oh;
              woke_q <= 1'b1;
            end
          end
          ST_WAIT: begin
            if (tmr_done) st_q <= ST_IDLE;
          end
          default: st_q <= st_q;
        endcase
      end
    end
  end

  // R1: fixed routing passes the programmed core straight through
  a_r1_fixed_route: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && irq_pend_i && !irq_mode_i)
      |=> (tgt_vld_o && tgt_o == $past(irq_fixed_i)));

  // R11: a held result does not move while the interrupt stays pending
  a_r11_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_HOLD && irq_pend_i) |=> ($stable(tgt_o) && tgt_vld_o));

  // R11: dropping the request clears the outputs on the next clock
  a_r11_drop_clears: assert property (@(posedge clk) disable iff (rst)
    !irq_pend_i |=> (!tgt_vld_o && wake_o == '0));

  // R10: a wake request names one core, and that core was asleep
  a_r10_wake_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wake_o));
  a_r10_wake_asleep: assert property (@(posedge clk) disable iff (rst)
    (wake_o != '0) |-> ((wake_o & ~$past(core_asleep_i)) == '0));

  // R10: wake is a single-clock pulse
  a_r10_wake_pulse: assert property (@(posedge clk) disable iff (rst)
    (wake_o != '0) |=> (wake_o == '0));

endmodule

// File: tb/sim_oon_target_sel.sv
module sim_oon_target_sel;
  localparam int N      = 4;
  localparam int NGRP   = 2;
  localparam int PRIO_W = 4;
  localparam int REEVAL = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0]  act, slp, cls, pany, wk;
  logic [7:0]  dis, gen;
  logic [15:0] pprio;
  logic [1:0]  glob, cm, fix, tgt;
  logic        wen, pend, grp, mode, vld;
  logic [3:0]  prio;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  oon_target_sel #(.N(N), .NGRP(NGRP), .PRIO_W(PRIO_W), .REEVAL_CYC(REEVAL)) u0 (
    .clk(clk), .rst(rst),
    .core_active_i(act), .core_asleep_i(slp), .core_grp_dis_i(dis),
    .core_grp_en_i(gen), .core_class_i(cls), .core_pend_any_i(pany),
    .core_pend_prio_i(pprio), .glob_grp_en_i(glob), .wake_en_i(wen),
    .irq_pend_i(pend), .irq_grp_i(grp), .irq_prio_i(prio), .irq_mode_i(mode),
    .irq_fixed_i(fix), .irq_cmask_i(cm),
    .tgt_o(tgt), .tgt_vld_o(vld), .wake_o(wk)
  );

  typedef struct packed {
    logic [3:0]  act, slp;
    logic [7:0]  dis, gen;
    logic [3:0]  cls, pany;
    logic [15:0] pprio;
    logic        grp;
    logic [3:0]  prio;
    logic        mode;
    logic [1:0]  fix, cm, glob;
    logic        wen;
    logic [1:0]  etgt;
    logic        evld;
    logic [3:0]  ewk;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    // R1 fixed routing ignores every core condition
    '{4'hF,4'hF,8'h00,8'hFF,4'h0,4'h0,16'h0000,1'b0,4'd8,1'b0,2'd2,2'd3,2'd3,1'b0, 2'd2,1'b1,4'h0,4'd1},
    // R5 all idle and active: pointer at core 0
    '{4'hF,4'h0,8'h00,8'hFF,4'h0,4'h0,16'h0000,1'b0,4'd8,1'b1,2'd0,2'd3,2'd3,1'b0, 2'd0,1'b1,4'h0,4'd5},
    // R5 only cores 2,3 active
    '{4'hC,4'h0,8'h00,8'hFF,4'h0,4'h0,16'h0000,1'b0,4'd8,1'b1,2'd0,2'd3,2'd3,1'b0, 2'd2,1'b1,4'h0,4'd5},
    // R2 cores 0..2 asleep
    '{4'hF,4'h7,8'h00,8'hFF,4'h0,4'h0,16'h0000,1'b0,4'd8,1'b1,2'd0,2'd3,2'd3,1'b0, 2'd3,1'b1,4'h0,4'd2},
    // R2 group 1 processor-disabled on cores 0,1
    '{4'hF,4'h0,8'h00,8'hF5,4'h0,4'h0,16'h0000,1'b1,4'd8,1'b1,2'd0,2'd3,2'd3,1'b0, 2'd2,1'b1,4'h0,4'd2},
    // R2 group 1 globally disabled: nothing legal
    '{4'hF,4'h0,8'h00,8'hFF,4'h0,4'h0,16'h0000,1'b1,4'd8,1'b1,2'd0,2'd3,2'd1,1'b0, 2'd0,1'b0,4'h0,4'd2},
    // R3 disabled-group bits on cores 0,2 for group 0
    '{4'hF,4'h0,8'h11,8'hFF,4'h0,4'h0,16'h0000,1'b0,4'd8,1'b1,2'd0,2'd3,2'd3,1'b0, 2'd1,1'b1,4'h0,4'd3},
    // R4 class-0-only mask, cores 0,1 in class 1
    '{4'hF,4'h0,8'h00,8'hFF,4'h3,4'h0,16'h0000,1'b0,4'd8,1'b1,2'd0,2'd1,2'd3,1'b0, 2'd2,1'b1,4'h0,4'd4},
    // R4 class-1-only mask, only core 2 in class 1
    '{4'hF,4'h0,8'h00,8'hFF,4'h4,4'h0,16'h0000,1'b0,4'd8,1'b1,2'd0,2'd2,2'd3,1'b0, 2'd2,1'b1,4'h0,4'd4},
    // R6 core0 holds prio 3 (more urgent), core1 holds equal prio 8
    '{4'h0,4'h0,8'h00,8'hFF,4'h0,4'hF,16'h2983,1'b0,4'd8,1'b1,2'd0,2'd3,2'd3,1'b0, 2'd1,1'b1,4'h0,4'd6},
    // R5 idle active core 3 beats less-urgent-busy core 0
    '{4'h8,4'h0,8'h00,8'hFF,4'h0,4'h7,16'hFFFF,1'b0,4'd8,1'b1,2'd0,2'd3,2'd3,1'b0, 2'd3,1'b1,4'h0,4'd5},
    // R8 no core active: still selected
    '{4'h0,4'h0,8'h00,8'hFF,4'h0,4'h0,16'h0000,1'b0,4'd8,1'b1,2'd0,2'd3,2'd3,1'b0, 2'd0,1'b1,4'h0,4'd8},
    // R7 every core busy with more urgent work: fallback
    '{4'hF,4'h0,8'h00,8'hFF,4'h0,4'hF,16'h1111,1'b0,4'd5,1'b1,2'd0,2'd3,2'd3,1'b0, 2'd0,1'b1,4'h0,4'd7},
    // R10 all asleep with wake enabled
    '{4'hF,4'hF,8'h00,8'hFF,4'h0,4'h0,16'h0000,1'b0,4'd8,1'b1,2'd0,2'd3,2'd3,1'b1, 2'd0,1'b0,4'h1,4'd10},
    // R10 core 0 filtered by disabled-group bit, so core 1 woken
    '{4'hF,4'hF,8'h01,8'hFF,4'h0,4'h0,16'h0000,1'b0,4'd8,1'b1,2'd0,2'd3,2'd3,1'b1, 2'd0,1'b0,4'h2,4'd10},
    // R10 awake core 1 passes filters (only its processor enable is off): no wake
    '{4'hF,4'hD,8'h00,8'hFB,4'h0,4'h0,16'h0000,1'b0,4'd8,1'b1,2'd0,2'd3,2'd3,1'b1, 2'd0,1'b0,4'h0,4'd10},
    // R10 wake disabled
    '{4'hF,4'hF,8'h00,8'hFF,4'h0,4'h0,16'h0000,1'b0,4'd8,1'b1,2'd0,2'd3,2'd3,1'b0, 2'd0,1'b0,4'h0,4'd10},
    // R4 both-classes mask admits mixed classes
    '{4'hF,4'h0,8'h00,8'hFF,4'h5,4'h0,16'h0000,1'b0,4'd8,1'b1,2'd0,2'd3,2'd3,1'b0, 2'd0,1'b1,4'h0,4'd4}
  };

  task automatic chk(input string tag, input int actv, input int expv);
    n_run++;
    if (actv != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actv, expv);
    end
  endtask

  task automatic base();
    act = 4'hF; slp = 4'h0; dis = 8'h00; gen = 8'hFF; cls = 4'h0; pany = 4'h0;
    pprio = 16'h0000; grp = 1'b0; prio = 4'd8; mode = 1'b1; fix = 2'd0;
    cm = 2'd3; glob = 2'd3; wen = 1'b0; pend = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; pend = 1'b0;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic pulse_req(); // drop one cycle, then raise and wait one evaluation
    pend = 1'b0; @(negedge clk);
    chk("R11 valid cleared after drop", int'(vld), 0);
    pend = 1'b1; @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int wakes;
    base();
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    // R12 reset state
    chk("R12 tgt in reset", int'(tgt), 0);
    chk("R12 vld in reset", int'(vld), 0);
    chk("R12 wake in reset", int'(wk), 0);

    for (int i = 0; i < NV; i++) begin
      do_reset();
      act = VEC[i].act; slp = VEC[i].slp; dis = VEC[i].dis; gen = VEC[i].gen;
      cls = VEC[i].cls; pany = VEC[i].pany; pprio = VEC[i].pprio; grp = VEC[i].grp;
      prio = VEC[i].prio; mode = VEC[i].mode; fix = VEC[i].fix; cm = VEC[i].cm;
      glob = VEC[i].glob; wen = VEC[i].wen; pend = 1'b1;
      @(negedge clk);
      chk($sformatf("R%0d vec%0d tgt", VEC[i].req, i), int'(tgt), int'(VEC[i].etgt));
      chk($sformatf("R%0d vec%0d vld", VEC[i].req, i), int'(vld), int'(VEC[i].evld));
      chk($sformatf("R%0d vec%0d wake", VEC[i].req, i), int'(wk), int'(VEC[i].ewk));
      pend = 1'b0;
    end

    // R9 shared pointer across passes, with wrap
    base(); do_reset();
    pend = 1'b1; @(negedge clk);
    chk("R9 first grant core0", int'(tgt), 0);
    pulse_req();
    chk("R9 second grant core1", int'(tgt), 1);
    act = 4'h0;
    pulse_req();
    chk("R9 pass2 continues at core2", int'(tgt), 2);
    pulse_req();
    chk("R9 grant core3", int'(tgt), 3);
    act = 4'hF;
    pulse_req();
    chk("R9 wrap to core0", int'(tgt), 0);

    // R11 held result ignores later core changes
    slp = 4'hF; pany = 4'hF;
    repeat (3) @(negedge clk);
    chk("R11 held tgt", int'(tgt), 0);
    chk("R11 held vld", int'(vld), 1);

    // R1 fixed routing leaves the pointer alone
    base(); do_reset();
    mode = 1'b0; fix = 2'd3; pend = 1'b1; @(negedge clk);
    chk("R1 fixed tgt", int'(tgt), 3);
    mode = 1'b1;
    pulse_req();
    chk("R1 pointer untouched by fixed route", int'(tgt), 0);

    // R7 fallback held, then re-evaluated
    base(); do_reset();
    pany = 4'hF; pprio = 16'h1111; prio = 4'd5; pend = 1'b1;
    @(negedge clk);
    chk("R7 fallback grant", int'(tgt), 0);
    pany = 4'hB;
    @(negedge clk);
    chk("R7 fallback held in window", int'(tgt), 0);
    repeat (REEVAL + 2) @(negedge clk);
    chk("R7 re-evaluated to idle core2", int'(tgt), 2);
    chk("R7 re-evaluated valid", int'(vld), 1);

    // R10 single wake per pending episode
    base(); do_reset();
    slp = 4'hF; wen = 1'b1; pend = 1'b1;
    @(negedge clk);
    chk("R10 first wake", int'(wk), 1);
    wakes = 0;
    for (int c = 0; c < 3 * REEVAL; c++) begin
      @(negedge clk);
      if (wk != 4'h0) wakes++;
    end
    chk("R10 no further wakes", wakes, 0);
    pend = 1'b0; @(negedge clk);
    pend = 1'b1; @(negedge clk);
    chk("R10 new episode wakes again", int'(wk), 1);
    pend = 1'b0; @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule